// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Arbiter

This block gathers interrupt requests from a row of peripheral slots that share one request line to a processor. Each slot keeps a pending flag that its local request input sets. The request line to the processor is high while any slot has a pending flag. When the processor raises its acknowledge input, the acknowledge is offered to the slots one after another along a grant chain. A slot that has a pending flag keeps the grant and blocks the chain for every slot behind it. A slot with no pending flag passes the grant on to the next slot.

Slot 0 sits next to the processor and has the highest priority. The slot that wins the acknowledge places its own fixed vector on the vector output, and its pending flag is cleared in the same edge. The winner is fixed on the first edge on which the acknowledge is seen high. It stays the owner until the acknowledge is seen low, so requests that arrive in the meantime wait for the next acknowledge.

Top module: `irq_chain_arbiter`

## Requirements
- R1: While `rst_n` is low, all pending flags and the owner are cleared; `intr_o`, `vec_valid_o` and `vec_o` read 0 after reset.
- R2: A clock edge that samples `req_i[i]` high sets the pending flag of slot i. `intr_o` is high in the cycle after such an edge, and it stays high until every pending flag has been cleared by an acknowledge.
- R3: On the first edge that samples `inta_i` high after an edge that sampled it low, the owner is the lowest-numbered slot whose pending flag was set before that edge. Slot 0 is nearest the processor.
- R4: The owner's vector is `VEC_BASE + i*VEC_STEP`, which is 0x20, 0x24, 0x28 and 0x2C for slots 0 to 3 with the defaults. `vec_valid_o` is high and `vec_o` carries that vector from the cycle after the acknowledge start until the first edge that samples `inta_i` low.
- R5: If no slot owns the acknowledge, `vec_o` is 0 and `vec_valid_o` is low. This includes an acknowledge that starts with no flag pending.
- R6: The owner's pending flag is cleared on the acknowledge-start edge. `intr_o` falls in the next cycle if no other flag is pending.
- R7: A request sampled on the acknowledge-start edge, or later while `inta_i` stays high, does not change the owner of that acknowledge. It stays pending and is served by a later acknowledge.
- R8: A request from the owning slot that arrives during its own acknowledge sets its pending flag again.
- R9: At most one slot owns the acknowledge at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SLOTS | Per-slot request; a high sample sets that slot's pending flag |
| inta_i | input | 1 | Acknowledge from the processor |
| intr_o | output | 1 | Shared request line, high while any flag is pending |
| vec_o | output | VEC_W | Vector of the owning slot, 0 when there is no owner |
| vec_valid_o | output | 1 | High while a slot owns the acknowledge |

## Verification
The assertions assume that `inta_i` is a clean level that is held for whole cycles. They also assume that the processor only raises it as an answer to the shared line, although an acknowledge with nothing pending is still allowed and must give no owner. The stimulus changes `req_i` and `inta_i` only on the falling edge and holds each for at least one full cycle. Every acknowledge is closed by at least one cycle with `inta_i` low, so that each new acknowledge makes a fresh start edge. Some requests are placed on the start edge and inside an open acknowledge on purpose, to exercise the waiting rule.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    localparam int unsigned DEF_SLOTS    = 4;
    localparam int unsigned DEF_VEC_W    = 8;
    localparam int unsigned DEF_VEC_BASE = 32;
    localparam int unsigned DEF_VEC_STEP = 4;

    // Vector value of one slot, returned wide and cut to width by the caller.
    function automatic logic [31:0] slot_vector(input int unsigned base,
                                                input int unsigned step,
                                                input int unsigned idx);
        return 32'(base + idx * step);
    endfunction
endpackage

// File: rtl/irq_chain_link.sv
module irq_chain_link (
    input  logic prio_in,
    input  logic pending,
    output logic prio_out,
    output logic take
);
    // A pending slot keeps the grant and blocks the slots behind it; an idle slot passes it on.
    always_comb begin
        take     = prio_in & pending;
        prio_out = prio_in & ~pending;
    end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select #(
    parameter int unsigned NUM_SLOTS = irq_chain_pkg::DEF_SLOTS,
    parameter int unsigned VEC_W     = irq_chain_pkg::DEF_VEC_W,
    parameter int unsigned VEC_BASE  = irq_chain_pkg::DEF_VEC_BASE,
    parameter int unsigned VEC_STEP  = irq_chain_pkg::DEF_VEC_STEP
) (
    input  logic [NUM_SLOTS-1:0] owner,
    output logic [VEC_W-1:0]     vec
);
    logic [VEC_W-1:0] term [NUM_SLOTS];
    logic [VEC_W-1:0] acc  [NUM_SLOTS+1];

    assign acc[0] = '0;

    // AND-OR selection: only the single owner's term is non-zero.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_term
        localparam logic [VEC_W-1:0] SLOT_VEC =
            VEC_W'(irq_chain_pkg::slot_vector(VEC_BASE, VEC_STEP, s));
        assign term[s]  = owner[s] ? SLOT_VEC : '0;
        assign acc[s+1] = acc[s] | term[s];
    end

    assign vec = acc[NUM_SLOTS];
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
    parameter int unsigned NUM_SLOTS = irq_chain_pkg::DEF_SLOTS,
    parameter int unsigned VEC_W     = irq_chain_pkg::DEF_VEC_W,
    parameter int unsigned VEC_BASE  = irq_chain_pkg::DEF_VEC_BASE,
    parameter int unsigned VEC_STEP  = irq_chain_pkg::DEF_VEC_STEP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic                 inta_i,
    output logic                 intr_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic                 vec_valid_o
);
    localparam int unsigned LINKS = NUM_SLOTS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
        logic [NUM_SLOTS-1:0] owner;
        logic                 inta_seen;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [LINKS:0]       chain;
    logic [NUM_SLOTS-1:0] grant;
    logic                 ack_start;

    // The chain head is driven by the acknowledge start; slot 0 is nearest the processor.
    assign chain[0] = ack_start;

    for (genvar s = 0; s < LINKS; s++) begin : g_link
        irq_chain_link link_i (
            .prio_in  (chain[s]),
            .pending  (st_q.pend[s]),
            .prio_out (chain[s+1]),
            .take     (grant[s])
        );
    end

    always_comb begin
        st_d           = st_q;
        ack_start      = inta_i & ~st_q.inta_seen;
        st_d.inta_seen = inta_i;
        if (!inta_i) begin
            st_d.owner = '0;
        end else if (ack_start) begin
            st_d.owner = grant;
        end
        // The winner drops its flag; new requests (the winner's own too) set flags again.
        st_d.pend = (st_q.pend & ~grant) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irq_vec_select #(
        .NUM_SLOTS (NUM_SLOTS),
        .VEC_W     (VEC_W),
        .VEC_BASE  (VEC_BASE),
        .VEC_STEP  (VEC_STEP)
    ) vsel_i (
        .owner (st_q.owner),
        .vec   (vec_o)
    );

    assign intr_o      = |st_q.pend;
    assign vec_valid_o = |st_q.owner;

    // R9: the chain never yields two owners.
    p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.owner));

    // R5: no owner means an all-zero vector.
    p_idle_vec_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == '0));

    // R3: an owner can only appear when the shared line was already raised.
    p_owner_needs_intr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid_o) |-> $past(intr_o));

    // R7: once owned, the acknowledge keeps its vector while inta stays high.
    p_no_takeover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inta_i) && $past(vec_valid_o)) |-> (vec_valid_o && $stable(vec_o)));

    // R4: ownership ends in the cycle after inta is seen low.
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> !vec_valid_o);
endmodule

// File: tb/irq_chain_arbiter_tb.sv
module irq_chain_arbiter_tb_top;
    localparam int unsigned N  = 4;
    localparam int unsigned VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic          inta_i = 1'b0;
    logic          intr_o;
    logic [VW-1:0] vec_o;
    logic          vec_valid_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_chain_arbiter #(.NUM_SLOTS(N), .VEC_W(VW), .VEC_BASE(32), .VEC_STEP(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .inta_i      (inta_i),
        .intr_o      (intr_o),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    // Row: {tag[3:0], req[3:0], inta, exp_intr, exp_valid, pad, exp_vec[7:0]}
    localparam int ROWS = 28;
    localparam logic [19:0] VEC_TAB [ROWS] = '{
        {4'd1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 idle
        {4'd2, 4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 slot2 pends
        {4'd4, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h28}, // R4 R6 slot2 owns
        {4'd7, 4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 8'h28}, // R7 late request waits
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R4 release
        {4'd7, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20}, // R7 served next time
        {4'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd2, 4'b1010, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 two pend
        {4'd3, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h24}, // R3 nearer slot1 wins
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2C}, // R6 last flag dropped
        {4'd8, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h2C}, // R8 owner re-requests
        {4'd8, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd8, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2C},
        {4'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R5 empty ack
        {4'd5, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd7, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R7 request on start edge
        {4'd7, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R7 no capture mid-ack
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd3, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h20}, // R3 slot0
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd3, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h24}, // R3 slot1
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd3, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h28}, // R3 slot2
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2C}, // R6 slot3, line drops
        {4'd9, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}  // R9 all released
    };

    task automatic check_out(input int tag, input logic e_intr, input logic e_val,
                             input logic [VW-1:0] e_vec);
        checks++;
        if (intr_o !== e_intr || vec_valid_o !== e_val || vec_o !== e_vec) begin
            fails++;
            $display("FAIL R%0d: got intr=%b valid=%b vec=%h, expected intr=%b valid=%b vec=%h",
                     tag, intr_o, vec_valid_o, vec_o, e_intr, e_val, e_vec);
        end
    endtask

    // Drive on the falling edge, one rising edge later check on the next falling edge.
    task automatic cycle(input logic [N-1:0] r, input logic a);
        req_i  = r;
        inta_i = a;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        check_out(1, 1'b0, 1'b0, '0); // R1 outputs during reset
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < ROWS; i++) begin
            cycle(VEC_TAB[i][15:12], VEC_TAB[i][11]);
            check_out(int'(VEC_TAB[i][19:16]), VEC_TAB[i][10], VEC_TAB[i][9],
                      VEC_TAB[i][7:0]);
        end

        // R2: a held request keeps the line up; pending survives idle cycles.
        cycle(4'b0010, 1'b0);
        cycle(4'b0000, 1'b0);
        cycle(4'b0000, 1'b0);
        check_out(2, 1'b1, 1'b0, '0);
        // R3 corner: furthest slot pends together with slot1; slot1 must still win.
        cycle(4'b1000, 1'b0);
        cycle(4'b0000, 1'b1);
        check_out(3, 1'b1, 1'b1, 8'h24);
        // R4: owner stays over a long acknowledge.
        cycle(4'b0000, 1'b1);
        cycle(4'b0000, 1'b1);
        check_out(4, 1'b1, 1'b1, 8'h24);
        cycle(4'b0000, 1'b0);
        check_out(4, 1'b1, 1'b0, '0);

        // R1: reset in the middle of activity clears flags and owner.
        cycle(4'b0000, 1'b1);
        check_out(3, 1'b0, 1'b1, 8'h2C);
        rst_n = 1'b0;
        #1;
        check_out(1, 1'b0, 1'b0, '0);
        cycle(4'b0000, 1'b0);
        rst_n = 1'b1;
        cycle(4'b0000, 1'b0);
        check_out(1, 1'b0, 1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule